// File: doc/BRIEF.md
# Dead-Band and Polarity Output Stage

This block turns two raw PWM waveforms into a gate-drive pair for one half-bridge leg. One path delays only rising edges and the other delays only falling edges. Each delay is a 10-bit count of clock cycles. Two select bits choose which raw signal feeds each delay path. Two mode bits choose, for each output, either its delayed path or its raw input. Two polarity bits invert each output after the delay. The usual setting is A straight and B inverted, which gives a complementary pair with a gap in it.

A one-shot trip input forces both outputs low in the same cycle it is seen. The trip stays latched until a clear is applied. When the interrupt enable is set, a trip also raises an interrupt flag, and the same clear resets that flag. After reset, both outputs stay low until the source of the rising-edge path first goes high. This stops the inverted output from putting out a high pulse before the first real PWM period.

Top module: `dead_band_stage`

## Requirements
- R1: With `out_mode[0]`=1, the A output rises exactly `red_dly` cycles after the rising-path source rises, provided the source stays high that long. It falls in the same cycle the source falls. `red_dly` is 10 bits (0 to 1023).
- R2: With `out_mode[1]`=1, the falling-edge path falls exactly `fed_dly` cycles after its source falls, provided the source stays low that long. It rises in the same cycle the source rises. `fed_dly` is 10 bits.
- R3: A delay of 0 passes the edge through in the same cycle. A pulse shorter than the programmed delay never shows on the delayed path.
- R4: `out_mode[0]`=1 selects the rising-delay path for A, and 0 selects raw A. `out_mode[1]`=1 selects the falling-delay path for B, and 0 selects raw B.
- R5: `in_sel[0]` picks the rising-path source (0 = raw A, 1 = raw B). `in_sel[1]` picks the falling-path source (0 = raw A, 1 = raw B).
- R6: `polarity[0]`=1 inverts A and `polarity[1]`=1 inverts B, both after the delay. The value 2'b10 gives A straight and B inverted.
- R7: After reset, both outputs are low until the first cycle in which the rising-path source is high. From that cycle on, normal output applies.
- R8: While `trip_in` is high, both outputs are low in that same cycle. The trip stays latched, holding both outputs low, until a cycle with `trip_clr`=1 and `trip_in`=0.
- R9: A cycle with `trip_in`=1 and `trip_irq_en`=1 sets `trip_irq` from the next cycle on. A cycle with `trip_clr`=1 and `trip_in`=0 clears it. With the enable low, a trip leaves the flag unchanged.
- R10: Set full mode, polarity 2'b10 and both paths fed from raw A. The falling edge of B and the next rising edge of A are then exactly `red_dly` cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time-base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_a | input | 1 | Raw PWM A |
| raw_b | input | 1 | Raw PWM B |
| red_dly | input | 10 | Rising-edge delay in cycles |
| fed_dly | input | 10 | Falling-edge delay in cycles |
| out_mode | input | 2 | Per-output delayed/raw select |
| polarity | input | 2 | Per-output inversion |
| in_sel | input | 2 | Delay path source selects |
| trip_in | input | 1 | One-shot trip request |
| trip_irq_en | input | 1 | Trip interrupt enable |
| trip_clr | input | 1 | Clears trip latch and flag |
| pwm_a | output | 1 | Final A output |
| pwm_b | output | 1 | Final B output |
| trip_irq | output | 1 | Trip interrupt flag |

## Verification
The main target is startup with B inverted. A design that let the inverted path run before the first period would drive B high for a number of cycles that depends on the delay. Delays of zero and pulses shorter than the delay are exercised as well. An off-by-one counter would move each edge by one cycle, and a counter that does not restart would let a short glitch through. The bench also measures the gap from B falling to A rising. Trips are sent during high phases, together with a clear in the same cycle and with the interrupt disabled. A latch that loses a trip, or a flag that ignores its enable, shows up as a mismatch in those cycles.

// File: rtl/dbp_pkg.sv
package dbp_pkg;

  // Which edge of the source a delay path holds back.
  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_kind_e;

  // Source routing: pick raw B when the select is set, else raw A.
  function automatic logic route_src(input logic a, input logic b, input logic pick_b);
    return pick_b ? b : a;
  endfunction

  // Polarity is an XOR applied after the delay stage.
  function automatic logic apply_pol(input logic s, input logic invert);
    return s ^ invert;
  endfunction

endpackage

// File: rtl/dbp_edge_delay.sv
module dbp_edge_delay
  import dbp_pkg::*;
#(
  parameter int unsigned DLY_W = 10,
  parameter edge_kind_e  KIND  = EDGE_RISE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src,
  input  logic [DLY_W-1:0] dly,
  output logic             dly_out
);

  // "act" is the phase whose entry edge is delayed.
  logic             act;
  logic             done_q;
  logic [DLY_W-1:0] cnt_q;
  logic             reached;
  logic             dact;

  generate
    if (KIND == EDGE_RISE) begin : g_rise
      assign act     = src;
      assign dly_out = dact;
    end else begin : g_fall
      assign act     = ~src;
      assign dly_out = ~dact;
    end
  endgenerate

  assign reached = done_q | (cnt_q >= dly);
  assign dact    = act & reached;

  // Reset to the settled state: delayed output equals the input level.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b1;
    end else if (act) begin
      done_q <= reached;
      if (!reached) cnt_q <= cnt_q + 1'b1;
    end else begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end
  end

endmodule

// File: rtl/dbp_trip_latch.sv
module dbp_trip_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_in,
  input  logic trip_clr,
  input  logic irq_en,
  output logic force_low,
  output logic latched,
  output logic irq_flag
);

  logic latch_q;
  logic irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (trip_in)       latch_q <= 1'b1;
      else if (trip_clr) latch_q <= 1'b0;
      if (trip_in && irq_en)  irq_q <= 1'b1;
      else if (!trip_in && trip_clr) irq_q <= 1'b0;
    end
  end

  assign force_low = trip_in | latch_q;
  assign latched   = latch_q;
  assign irq_flag  = irq_q;

endmodule

// File: rtl/dead_band_stage.sv
module dead_band_stage
  import dbp_pkg::*;
#(
  parameter int unsigned DLY_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raw_a,
  input  logic             raw_b,
  input  logic [DLY_W-1:0] red_dly,
  input  logic [DLY_W-1:0] fed_dly,
  input  logic [1:0]       out_mode,
  input  logic [1:0]       polarity,
  input  logic [1:0]       in_sel,
  input  logic             trip_in,
  input  logic             trip_irq_en,
  input  logic             trip_clr,
  output logic             pwm_a,
  output logic             pwm_b,
  output logic             trip_irq
);

  logic rise_src, fall_src;
  logic red_out, fed_out;
  logic a_pre, b_pre, a_pol, b_pol;
  logic started_q, run_en;
  logic force_low, trip_latched;

  assign rise_src = route_src(raw_a, raw_b, in_sel[0]);
  assign fall_src = route_src(raw_a, raw_b, in_sel[1]);

  dbp_edge_delay #(.DLY_W(DLY_W), .KIND(EDGE_RISE)) u_red (
    .clk(clk), .rst_n(rst_n), .src(rise_src), .dly(red_dly), .dly_out(red_out)
  );

  dbp_edge_delay #(.DLY_W(DLY_W), .KIND(EDGE_FALL)) u_fed (
    .clk(clk), .rst_n(rst_n), .src(fall_src), .dly(fed_dly), .dly_out(fed_out)
  );

  dbp_trip_latch u_trip (
    .clk(clk), .rst_n(rst_n), .trip_in(trip_in), .trip_clr(trip_clr),
    .irq_en(trip_irq_en), .force_low(force_low), .latched(trip_latched),
    .irq_flag(trip_irq)
  );

  // Startup gate: outputs stay low until the first period begins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        started_q <= 1'b0;
    else if (rise_src) started_q <= 1'b1;
  end
  assign run_en = started_q | rise_src;

  assign a_pre = out_mode[0] ? red_out : raw_a;
  assign b_pre = out_mode[1] ? fed_out : raw_b;
  assign a_pol = apply_pol(a_pre, polarity[0]);
  assign b_pol = apply_pol(b_pre, polarity[1]);

  assign pwm_a = run_en & ~force_low & a_pol;
  assign pwm_b = run_en & ~force_low & b_pol;

endmodule

// File: rtl/dbp_checker.sv
module dbp_checker #(
  parameter int unsigned DLY_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             raw_a,
  input logic             raw_b,
  input logic [DLY_W-1:0] red_dly,
  input logic [1:0]       out_mode,
  input logic [1:0]       polarity,
  input logic [1:0]       in_sel,
  input logic             trip_in,
  input logic             trip_irq_en,
  input logic             trip_clr,
  input logic             pwm_a,
  input logic             pwm_b,
  input logic             trip_irq,
  input logic             started,
  input logic             trip_latched
);

  a_r8_trip_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    trip_in |-> (!pwm_a && !pwm_b));

  a_r8_latch_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    trip_latched |-> (!pwm_a && !pwm_b));

  a_r8_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_latched && !trip_clr) |=> trip_latched);

  a_r9_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_in && trip_irq_en) |=> trip_irq);

  a_r9_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_clr && !trip_in) |=> !trip_irq);

  a_r7_startup_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!started && !(in_sel[0] ? raw_b : raw_a)) |-> (!pwm_a && !pwm_b));

  a_r3_zero_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (red_dly == '0 && out_mode[0] && !polarity[0] && !in_sel[0]
     && !trip_in && !trip_latched) |-> (pwm_a == raw_a));

endmodule

bind dead_band_stage dbp_checker #(.DLY_W(DLY_W)) u_dbp_chk (
  .clk(clk), .rst_n(rst_n), .raw_a(raw_a), .raw_b(raw_b), .red_dly(red_dly),
  .out_mode(out_mode), .polarity(polarity), .in_sel(in_sel),
  .trip_in(trip_in), .trip_irq_en(trip_irq_en), .trip_clr(trip_clr),
  .pwm_a(pwm_a), .pwm_b(pwm_b), .trip_irq(trip_irq),
  .started(started_q), .trip_latched(trip_latched)
);

// File: tb/tb_dead_band_stage.sv
`timescale 1ns/1ps
module tb_dead_band_stage;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic raw_a = 0, raw_b = 0, trip_in = 0, trip_clr = 0, trip_irq_en = 1;
  logic [9:0] red_dly = 10'd3, fed_dly = 10'd3;
  logic [1:0] out_mode = 2'b11, polarity = 2'b10, in_sel = 2'b10;
  logic pwm_a, pwm_b, trip_irq;

  int checks = 0, errors = 0, cyc = 0;
  string tag = "reset";
  bit hr[$];
  bit hf[$];
  bit started_m = 0, trip_m = 0, irq_m = 0;
  bit meas_on = 0;
  logic prev_a = 0, prev_b = 0;
  int bfall = -1;

  always #2.5 clk = ~clk;

  dead_band_stage dut (
    .clk(clk), .rst_n(rst_n), .raw_a(raw_a), .raw_b(raw_b),
    .red_dly(red_dly), .fed_dly(fed_dly), .out_mode(out_mode),
    .polarity(polarity), .in_sel(in_sel), .trip_in(trip_in),
    .trip_irq_en(trip_irq_en), .trip_clr(trip_clr),
    .pwm_a(pwm_a), .pwm_b(pwm_b), .trip_irq(trip_irq)
  );

  // Rising path high only if the source has been high for the last d+1 samples.
  function automatic bit rise_model(bit s, int d);
    if (!s) return 0;
    for (int i = 0; i < d; i++) if (!hr[i]) return 0;
    return 1;
  endfunction

  // Falling path high if the source was high in any of the last d+1 samples.
  function automatic bit fall_model(bit s, int d);
    if (s) return 1;
    for (int i = 0; i < d; i++) if (hf[i]) return 1;
    return 0;
  endfunction

  task automatic check(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: got %b expected %b", tag, what, cyc, act, exp);
    end
  endtask

  task automatic evaluate();
    bit rs, fs, ea, eb, en, frc;
    rs  = in_sel[0] ? raw_b : raw_a;
    fs  = in_sel[1] ? raw_b : raw_a;
    ea  = out_mode[0] ? rise_model(rs, red_dly) : raw_a;
    eb  = out_mode[1] ? fall_model(fs, fed_dly) : raw_b;
    ea  = ea != polarity[0];
    eb  = eb != polarity[1];
    en  = started_m || rs;
    frc = trip_in || trip_m;
    check(pwm_a, en && !frc && ea, "pwm_a");
    check(pwm_b, en && !frc && eb, "pwm_b");
    check(trip_irq, irq_m, "trip_irq");
    if (meas_on) begin  // R10: B fall to A rise gap
      if (prev_b && !pwm_b) bfall = cyc;
      if (!prev_a && pwm_a && bfall >= 0) begin
        checks++;
        if (cyc - bfall != int'(red_dly)) begin
          errors++;
          $display("FAIL R10 gap: got %0d expected %0d", cyc - bfall, red_dly);
        end
      end
    end
    prev_a = pwm_a;
    prev_b = pwm_b;
    hr.push_front(rs); void'(hr.pop_back());
    hf.push_front(fs); void'(hf.pop_back());
    if (rs) started_m = 1;
    if (trip_in && trip_irq_en) irq_m = 1;
    else if (!trip_in && trip_clr) irq_m = 0;
    if (trip_in) trip_m = 1;
    else if (trip_clr) trip_m = 0;
    cyc++;
  endtask

  task automatic step(input logic a, input logic b, input logic tr, input logic cl);
    @(negedge clk);
    raw_a = a; raw_b = b; trip_in = tr; trip_clr = cl;
    #1;
    evaluate();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0);
  endtask

  // Period of 2*half cycles; A high for ha cycles, B high for hb cycles from the start.
  task automatic pwm(input int periods, input int half, input int ha, input int hb);
    for (int p = 0; p < periods; p++)
      for (int t = 0; t < 2 * half; t++) step(t < ha, t < hb, 0, 0);
  endtask

  task automatic cfg(input int rd, input int fd, input logic [1:0] om,
                     input logic [1:0] pl, input logic [1:0] sl);
    idle(50);
    @(negedge clk);
    red_dly = 10'(rd); fed_dly = 10'(fd); out_mode = om; polarity = pl; in_sel = sl;
    #1;
    evaluate();
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin hr.push_back(0); hf.push_back(0); end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R7: reset state, B inverted but no pulse before the first period
    tag = "R7 startup";
    check(pwm_a, 0, "pwm_a reset");
    check(pwm_b, 0, "pwm_b reset");
    check(trip_irq, 0, "trip_irq reset");
    idle(20);
    tag = "R1 R2 R6 R7 complementary";
    pwm(4, 20, 12, 16);
    tag = "R10 gap";
    cfg(6, 4, 2'b11, 2'b10, 2'b00);
    meas_on = 1;
    pwm(3, 20, 10, 0);
    meas_on = 0;
    tag = "R3 zero delay";
    cfg(0, 0, 2'b11, 2'b00, 2'b10);
    pwm(2, 10, 5, 7);
    tag = "R3 absorb short pulse";
    cfg(5, 5, 2'b11, 2'b00, 2'b10);
    for (int i = 0; i < 3; i++) step(1, 1, 0, 0);
    for (int i = 0; i < 20; i++) step(0, 1, 0, 0);
    for (int i = 0; i < 2; i++) step(0, 0, 0, 0);
    for (int i = 0; i < 20; i++) step(0, 1, 0, 0);
    tag = "R4 modes";
    cfg(4, 2, 2'b00, 2'b10, 2'b10);
    pwm(2, 16, 9, 12);
    cfg(4, 2, 2'b01, 2'b10, 2'b10);
    pwm(2, 16, 9, 12);
    cfg(4, 2, 2'b10, 2'b10, 2'b10);
    pwm(2, 16, 9, 12);
    tag = "R5 sources";
    cfg(3, 5, 2'b11, 2'b10, 2'b01);
    pwm(2, 18, 7, 13);
    cfg(3, 5, 2'b11, 2'b10, 2'b11);
    pwm(2, 18, 7, 13);
    tag = "R6 polarity";
    cfg(2, 3, 2'b11, 2'b00, 2'b10);
    pwm(2, 14, 8, 10);
    cfg(2, 3, 2'b11, 2'b01, 2'b10);
    pwm(2, 14, 8, 10);
    cfg(2, 3, 2'b11, 2'b11, 2'b10);
    pwm(2, 14, 8, 10);
    tag = "R1 R2 long delays";
    cfg(40, 33, 2'b11, 2'b10, 2'b10);
    pwm(2, 60, 50, 45);
    tag = "R8 R9 trip";
    cfg(3, 3, 2'b11, 2'b10, 2'b10);
    pwm(1, 20, 12, 16);
    for (int i = 0; i < 6; i++) step(1, 1, 0, 0);
    step(1, 1, 1, 0);
    pwm(2, 20, 12, 16);
    step(1, 1, 1, 1);
    pwm(1, 20, 12, 16);
    step(0, 0, 0, 1);
    pwm(2, 20, 12, 16);
    tag = "R9 irq disabled";
    trip_irq_en = 0;
    step(1, 1, 1, 0);
    pwm(1, 20, 12, 16);
    step(0, 0, 0, 1);
    pwm(2, 20, 12, 16);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule